// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block is the hazard resolution logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). It has no state and works within a single cycle. It looks at the two source register numbers of the instruction in the decode/execute stage register. It compares them with the destination numbers and write enables held in the two later stage registers, and it drives a two-bit select for each ALU operand multiplexer. This lets the newest in-flight value of a register reach the ALU without waiting for write-back.

Two cases cannot be settled by operand selection alone. The first is a load whose destination is read by the instruction directly behind it. The value does not exist until the memory stage, so the unit raises a stall. The stall holds the program counter and the fetch/decode register, and it turns the control of the decode/execute register into a bubble for one cycle. The second case is a write-back to the register that the decode stage is reading in the same cycle. The unit bypasses the write data onto the register read ports, which gives the behaviour of a write-first-half, read-second-half register file.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (execute/memory stage result) when the execute/memory write enable is 1, its destination is nonzero, and its destination equals that operand's source (rs for operand A, rt for operand B).
- R2: An operand select is 2'b01 (memory/write-back stage result) when the memory/write-back write enable is 1, its destination is nonzero, it equals that operand's source, and R1 does not apply.
- R3: When both later stages match the same source, the select is 2'b10, so the newer value wins.
- R4: A destination of register 0 never produces a forwarding select, even with its write enable at 1.
- R5: With no qualifying match, an operand select is 2'b00 (register file value).
- R6: The stall is 1 exactly when the decode/execute memory-read flag is 1 and its rt equals the fetch/decode rs or rt.
- R7: The PC hold, fetch/decode hold and decode/execute bubble outputs all equal the stall, and all are 0 when no load-use hazard exists.
- R8: A decode read port returns the write-back data when the write-back write enable is 1, the write-back destination is nonzero, and it equals that port's address; otherwise it returns the register file data.
- R9: A write-back to register 0 is never bypassed; the read port then returns the register file data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs | input | 5 | Source A number in the decode/execute register |
| idex_rt | input | 5 | Source B number in the decode/execute register |
| idex_memread | input | 1 | Instruction in execute is a load |
| exmem_we | input | 1 | Register write enable of the execute/memory stage |
| exmem_rd | input | 5 | Destination of the execute/memory stage |
| memwb_we | input | 1 | Register write enable of the write-back stage |
| memwb_rd | input | 5 | Destination of the write-back stage |
| memwb_data | input | 32 | Data being written back |
| ifid_rs | input | 5 | Source A number of the instruction in decode |
| ifid_rt | input | 5 | Source B number of the instruction in decode |
| rf_rdata_a | input | 32 | Raw register array read for ifid_rs |
| rf_rdata_b | input | 32 | Raw register array read for ifid_rt |
| fwd_a_sel | output | 2 | Operand A multiplexer select |
| fwd_b_sel | output | 2 | Operand B multiplexer select |
| stall | output | 1 | Load-use hazard detected |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Zero the control of the decode/execute register |
| id_opnd_a | output | 32 | Decode read port A after bypass |
| id_opnd_b | output | 32 | Decode read port B after bypass |

## Verification
The hardest case to reach is the three-way collision: both later stages write the same nonzero register that one operand reads, sometimes with the other operand reading register 0 while a stage also targets register 0. Uniform register numbers almost never produce it. The random stimulus therefore draws register numbers from a range of four values, with zero included, so that double matches, zero-destination writes and load-use overlaps occur often. Directed cases then pin down the exact priority and zero-register corners.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_MEMWB   = 2'b01,
      SEL_EXMEM   = 2'b10
   } fwd_sel_t;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
   import hazard_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic          exmem_we,
   input  logic [AW-1:0] exmem_rd,
   input  logic          memwb_we,
   input  logic [AW-1:0] memwb_rd,
   output fwd_sel_t      sel
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic near_hit;
   logic far_hit;

   assign near_hit = exmem_we && (exmem_rd != ZERO_REG) && (exmem_rd == src);
   assign far_hit  = memwb_we && (memwb_rd != ZERO_REG) && (memwb_rd == src);

   always_comb begin
      if (near_hit)     sel = SEL_EXMEM;
      else if (far_hit) sel = SEL_MEMWB;
      else              sel = SEL_REGFILE;
   end

   always_comb begin
      // R4
      zero_src_chk: assert (!(src == ZERO_REG && sel != SEL_REGFILE))
         else $error("register zero forwarded");
      // R3
      newer_wins_chk: assert (!(sel == SEL_MEMWB && exmem_we && exmem_rd == src && src != ZERO_REG))
         else $error("older stage chosen over newer");
   end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
   parameter int AW = 5
) (
   input  logic          idex_memread,
   input  logic [AW-1:0] idex_rt,
   input  logic [AW-1:0] ifid_rs,
   input  logic [AW-1:0] ifid_rt,
   output logic          stall
);
   logic rs_dep;
   logic rt_dep;

   assign rs_dep = (idex_rt == ifid_rs);
   assign rt_dep = (idex_rt == ifid_rt);
   assign stall  = idex_memread && (rs_dep || rt_dep);

   always_comb begin
      // R6
      load_only_chk: assert (!(stall && !idex_memread))
         else $error("stall without a load");
   end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
   parameter int AW     = 5,
   parameter int DW     = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rf_data,
   input  logic          wb_we,
   input  logic [AW-1:0] wb_rd,
   input  logic [DW-1:0] wb_data,
   output logic [DW-1:0] data
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   generate
      if (ENABLE) begin : g_bypass
         logic hit;
         assign hit  = wb_we && (wb_rd != ZERO_REG) && (wb_rd == rd_addr);
         assign data = hit ? wb_data : rf_data;
      end else begin : g_plain
         assign data = rf_data;
      end
   endgenerate

   always_comb begin
      // R9
      zero_bypass_chk: assert (!(rd_addr == ZERO_REG && data != rf_data))
         else $error("write to register zero bypassed");
   end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
   import hazard_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter int DATA_W    = 32,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [REG_AW-1:0] idex_rs,
   input  logic [REG_AW-1:0] idex_rt,
   input  logic              idex_memread,
   input  logic              exmem_we,
   input  logic [REG_AW-1:0] exmem_rd,
   input  logic              memwb_we,
   input  logic [REG_AW-1:0] memwb_rd,
   input  logic [DATA_W-1:0] memwb_data,
   input  logic [REG_AW-1:0] ifid_rs,
   input  logic [REG_AW-1:0] ifid_rt,
   input  logic [DATA_W-1:0] rf_rdata_a,
   input  logic [DATA_W-1:0] rf_rdata_b,
   output logic [1:0]        fwd_a_sel,
   output logic [1:0]        fwd_b_sel,
   output logic              stall,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble,
   output logic [DATA_W-1:0] id_opnd_a,
   output logic [DATA_W-1:0] id_opnd_b
);
   localparam int NUM_OPND = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [REG_AW-1:0] ex_src   [NUM_OPND];
   fwd_sel_t          ex_sel   [NUM_OPND];
   logic [REG_AW-1:0] id_src   [NUM_OPND];
   logic [DATA_W-1:0] id_raw   [NUM_OPND];
   logic [DATA_W-1:0] id_out   [NUM_OPND];

   assign ex_src[0] = idex_rs;
   assign ex_src[1] = idex_rt;
   assign id_src[0] = ifid_rs;
   assign id_src[1] = ifid_rt;
   assign id_raw[0] = rf_rdata_a;
   assign id_raw[1] = rf_rdata_b;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         fwd_select #(.AW(REG_AW)) u_sel (
            .src      (ex_src[g]),
            .exmem_we (exmem_we),
            .exmem_rd (exmem_rd),
            .memwb_we (memwb_we),
            .memwb_rd (memwb_rd),
            .sel      (ex_sel[g])
         );
         rf_bypass #(.AW(REG_AW), .DW(DATA_W), .ENABLE(BYPASS_EN)) u_byp (
            .rd_addr (id_src[g]),
            .rf_data (id_raw[g]),
            .wb_we   (memwb_we),
            .wb_rd   (memwb_rd),
            .wb_data (memwb_data),
            .data    (id_out[g])
         );
      end
   endgenerate

   load_use_detect #(.AW(REG_AW)) u_lu (
      .idex_memread (idex_memread),
      .idex_rt      (idex_rt),
      .ifid_rs      (ifid_rs),
      .ifid_rt      (ifid_rt),
      .stall        (stall)
   );

   assign fwd_a_sel   = ex_sel[0];
   assign fwd_b_sel   = ex_sel[1];
   assign id_opnd_a   = id_out[0];
   assign id_opnd_b   = id_out[1];
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   always_comb begin
      // R7
      freeze_together_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
         else $error("freeze outputs disagree");
      // R5
      sel_legal_chk: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
         else $error("illegal select code");
   end
endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [4:0]  idex_rs, idex_rt, exmem_rd, memwb_rd, ifid_rs, ifid_rt;
   logic        idex_memread, exmem_we, memwb_we;
   logic [31:0] memwb_data, rf_rdata_a, rf_rdata_b;
   logic [1:0]  fwd_a_sel, fwd_b_sel;
   logic        stall, pc_hold, ifid_hold, idex_bubble;
   logic [31:0] id_opnd_a, id_opnd_b;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   hazard_unit u_hazard_unit (
      .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_memread(idex_memread),
      .exmem_we(exmem_we), .exmem_rd(exmem_rd),
      .memwb_we(memwb_we), .memwb_rd(memwb_rd), .memwb_data(memwb_data),
      .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
      .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .stall(stall), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .idex_bubble(idex_bubble),
      .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b)
   );

   function automatic logic [1:0] exp_sel(input logic [4:0] s);
      if (exmem_we && exmem_rd != 0 && exmem_rd == s) return 2'b10;
      if (memwb_we && memwb_rd != 0 && memwb_rd == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic [31:0] raw);
      if (memwb_we && memwb_rd != 0 && memwb_rd == a) return memwb_data;
      return raw;
   endfunction

   function automatic logic exp_stall();
      return idex_memread && (idex_rt == ifid_rs || idex_rt == ifid_rt);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " R1/R2/R3/R4/R5 sel A"}, 32'(fwd_a_sel), 32'(exp_sel(idex_rs)));
      check({tag, " R1/R2/R3/R4/R5 sel B"}, 32'(fwd_b_sel), 32'(exp_sel(idex_rt)));
      check({tag, " R6 stall"}, 32'(stall), 32'(exp_stall()));
      check({tag, " R7 freeze"}, {29'd0, pc_hold, ifid_hold, idex_bubble},
            {29'd0, {3{exp_stall()}}});
      check({tag, " R8/R9 port A"}, id_opnd_a, exp_rd(ifid_rs, rf_rdata_a));
      check({tag, " R8/R9 port B"}, id_opnd_b, exp_rd(ifid_rt, rf_rdata_b));
   endtask

   task automatic apply(input logic [4:0] rs, rt, input logic ld,
                        input logic ew, input logic [4:0] erd,
                        input logic mw, input logic [4:0] mrd,
                        input logic [4:0] frs, frt);
      @(negedge clk);
      idex_rs = rs; idex_rt = rt; idex_memread = ld;
      exmem_we = ew; exmem_rd = erd; memwb_we = mw; memwb_rd = mrd;
      ifid_rs = frs; ifid_rt = frt;
      memwb_data = $urandom; rf_rdata_a = $urandom; rf_rdata_b = $urandom;
      #2;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // quiet state
      apply(5'd1, 5'd2, 0, 0, 5'd0, 0, 5'd0, 5'd3, 5'd4);
      check("R5 idle sel A", 32'(fwd_a_sel), 32'd0);
      check("R7 idle no stall", 32'(stall), 32'd0);
      // R1 near forward on A
      apply(5'd7, 5'd2, 0, 1, 5'd7, 0, 5'd0, 5'd3, 5'd4);
      check("R1 near A", 32'(fwd_a_sel), 32'b10);
      // R2 far forward on B
      apply(5'd1, 5'd9, 0, 0, 5'd9, 1, 5'd9, 5'd3, 5'd4);
      check("R2 far B", 32'(fwd_b_sel), 32'b01);
      // R3 both match
      apply(5'd5, 5'd5, 0, 1, 5'd5, 1, 5'd5, 5'd3, 5'd4);
      check("R3 priority A", 32'(fwd_a_sel), 32'b10);
      check("R3 priority B", 32'(fwd_b_sel), 32'b10);
      // R4 zero destination
      apply(5'd0, 5'd0, 0, 1, 5'd0, 1, 5'd0, 5'd3, 5'd4);
      check("R4 zero A", 32'(fwd_a_sel), 32'd0);
      check("R4 zero B", 32'(fwd_b_sel), 32'd0);
      // R6/R7 load-use on rt
      apply(5'd1, 5'd8, 1, 0, 5'd0, 0, 5'd0, 5'd3, 5'd8);
      check("R6 load-use rt", 32'(stall), 32'd1);
      check("R7 freeze on", {29'd0, pc_hold, ifid_hold, idex_bubble}, 32'b111);
      // R6 load with no dependent use
      apply(5'd1, 5'd8, 1, 0, 5'd0, 0, 5'd0, 5'd3, 5'd4);
      check("R6 load no use", 32'(stall), 32'd0);
      // R8 bypass and R9 zero write
      apply(5'd1, 5'd2, 0, 0, 5'd0, 1, 5'd6, 5'd6, 5'd4);
      check("R8 bypass A", id_opnd_a, memwb_data);
      check("R8 no bypass B", id_opnd_b, rf_rdata_b);
      apply(5'd1, 5'd2, 0, 0, 5'd0, 1, 5'd0, 5'd0, 5'd0);
      check("R9 zero A", id_opnd_a, rf_rdata_a);
      check("R9 zero B", id_opnd_b, rf_rdata_b);
      // random with narrow register range
      for (int i = 0; i < 600; i++) begin
         apply(5'($urandom_range(3)), 5'($urandom_range(3)), 1'($urandom),
               1'($urandom), 5'($urandom_range(3)), 1'($urandom),
               5'($urandom_range(3)), 5'($urandom_range(3)), 5'($urandom_range(3)));
         check_all("rand");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule